// File: doc/BRIEF.md
# RTC Seconds Counter with Dual Alarms

This block is the register-side core of a real-time clock. A 32-bit seconds count advances by one on every pulse of an external one-second strobe. Two alarm channels each compare the count against their own 32-bit match value and raise a sticky flag when the count steps onto that value. Each channel has a three-bit interrupt setup: alarm enable, periodic enable, and periodic rate select. When periodic mode is on, the flag is also raised on every one-second strobe or on every pulse of a faster divided strobe, depending on the rate bit. The flags are cleared by writing ones to the status word. One level interrupt output is the OR of each channel's flag gated by its alarm enable.

Software reaches the block through a single-cycle register bus. Writes are applied on the next rising edge. Read data is a combinational function of the address. A scratch test word powers up with a nonzero low byte, which marks a clock that has never been set up. Software clears it during setup. A 32-bit trim word is stored for the calibration logic outside this block and has no effect here.

Top module: `rtc_core`

## Requirements
- R1: After reset the status, time, both alarm values, both interrupt setups and the trim word read 0, the test word reads 0x000000FF, and irq_o is 0.
- R2: Each tick_i pulse without a time write increments the time word by 1, wrapping from 0xFFFFFFFF to 0.
- R3: A write to the time word (byte address 0x0C) loads the count directly. When a tick arrives in the same cycle, the written value wins.
- R4: The alarm values (0x10 for channel 0, 0x14 for channel 1) read back what was written. The interrupt setups (0x04 for channel 0, 0x08 for channel 1) keep only bit 0 (alarm enable), bit 1 (periodic enable) and bit 2 (1 Hz rate select); their upper bits read 0.
- R5: A channel's flag (status bit 0 for channel 0, bit 1 for channel 1) sets on the tick at which the count becomes equal to that channel's alarm value, whether or not the alarm enable is set. Loading an equal value through a time write does not set it.
- R6: Writing the status word (0x00) clears each flag whose data bit is 1, and leaves flags whose data bit is 0 unchanged. A set condition in the same cycle wins over the clear.
- R7: irq_o is 1 exactly when some channel has its flag set and its alarm enable bit set. It falls once the flag is cleared or the enable is cleared.
- R8: With periodic enable set, a channel's flag sets on each tick_i when the rate bit is 1, and on each fast_i pulse when the rate bit is 0. With periodic enable clear, fast_i has no effect.
- R9: The test word (0x1C) holds what was written. Writing 0 clears the uninitialised mark in its low byte.
- R10: The trim word (0x18) reads back what was written and does not change how the count advances.
- R11: Addresses above 0x1C and addresses that are not word-aligned read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-second strobe, one cycle wide |
| fast_i | input | 1 | Faster divided strobe for periodic mode |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | Write when 1, read when 0 |
| addr_i | input | 6 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| irq_o | output | 1 | Level interrupt |

## Verification
Read data is combinational, so the bench samples rdata_o 1 ns after it drives the address, in the same cycle. Writes, ticks and fast strobes take effect at the next rising edge. Flags and the count are therefore read back one cycle after the stimulus. irq_o depends only on registered state, so it is sampled just after the edge that updated the flag or the enable, never before. The alarm check sweeps both channels over alarm distances of 0 to 5 seconds and six ticks. For each tick the expected flag is computed from the distance.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NUM_ALARM  = 2;
  // word indices (byte address >> 2)
  localparam int IDX_STATUS = 0;
  localparam int IDX_CFG0   = 1;
  localparam int IDX_TIME   = 3;
  localparam int IDX_ALM0   = 4;
  localparam int IDX_TRIM   = 6;
  localparam int IDX_TEST   = 7;
  localparam int CFG_W      = 3;

  typedef struct packed {
    logic one_hz;
    logic per_en;
    logic al_en;
  } irq_cfg_t;
endpackage

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          load_i,
  input  logic [DW-1:0] load_val_i,
  output logic [DW-1:0] count_o,
  output logic [DW-1:0] next_o,
  output logic          adv_o
);
  logic [DW-1:0] cnt_q;

  assign next_o  = cnt_q + 1'b1;
  assign adv_o   = tick_i & ~load_i;
  assign count_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (tick_i) cnt_q <= next_o;
  end
endmodule

// File: rtl/rtc_alarm_chan.sv
module rtc_alarm_chan import rtc_pkg::*; #(
  parameter int DW = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic             alm_we_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic             fast_i,
  input  logic             adv_i,
  input  logic [DW-1:0]    next_i,
  output logic             flag_o,
  output irq_cfg_t         cfg_o,
  output logic [DW-1:0]    alarm_o,
  output logic             irq_o
);
  irq_cfg_t      cfg_q;
  logic [DW-1:0] alm_q;
  logic          flag_q;
  logic          hit, per_hit, set;

  assign hit     = adv_i && (next_i == alm_q);
  assign per_hit = cfg_q.per_en && (cfg_q.one_hz ? tick_i : fast_i);
  assign set     = hit | per_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      alm_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (cfg_we_i) cfg_q <= irq_cfg_t'(wdata_i[CFG_W-1:0]);
      if (alm_we_i) alm_q <= wdata_i;
      // set beats a same-cycle clear
      if (set)        flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
    end
  end

  assign flag_o  = flag_q;
  assign cfg_o   = cfg_q;
  assign alarm_o = alm_q;
  assign irq_o   = flag_q & cfg_q.al_en;
endmodule

// File: rtl/rtc_core.sv
module rtc_core import rtc_pkg::*; #(
  parameter int         DW       = 32,
  parameter int         ADDR_W   = 6,
  parameter logic [7:0] TEST_RST = 8'hFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              fast_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              irq_o
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             aligned, wr;
  logic             time_wr, trim_wr, test_wr, stat_wr;
  logic [DW-1:0]    time_q, time_next;
  logic             time_adv;
  logic [DW-1:0]    trim_q, test_q;

  logic [NUM_ALARM-1:0] flag_vec, al_en_vec, irq_vec;
  irq_cfg_t             cfg_vec [NUM_ALARM];
  logic [DW-1:0]        alm_vec [NUM_ALARM];

  assign idx     = addr_i[ADDR_W-1:2];
  assign aligned = (addr_i[1:0] == 2'b00);
  assign wr      = req_i & we_i & aligned;
  assign time_wr = wr && (idx == IDX_W'(IDX_TIME));
  assign trim_wr = wr && (idx == IDX_W'(IDX_TRIM));
  assign test_wr = wr && (idx == IDX_W'(IDX_TEST));
  assign stat_wr = wr && (idx == IDX_W'(IDX_STATUS));

  rtc_sec_counter #(.DW(DW)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .load_i     (time_wr),
    .load_val_i (wdata_i),
    .count_o    (time_q),
    .next_o     (time_next),
    .adv_o      (time_adv)
  );

  for (genvar c = 0; c < NUM_ALARM; c++) begin : g_ch
    logic cfg_we, alm_we;
    assign cfg_we = wr && (idx == IDX_W'(IDX_CFG0 + c));
    assign alm_we = wr && (idx == IDX_W'(IDX_ALM0 + c));

    rtc_alarm_chan #(.DW(DW)) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .cfg_we_i (cfg_we),
      .alm_we_i (alm_we),
      .wdata_i  (wdata_i),
      .clr_i    (stat_wr & wdata_i[c]),
      .tick_i   (tick_i),
      .fast_i   (fast_i),
      .adv_i    (time_adv),
      .next_i   (time_next),
      .flag_o   (flag_vec[c]),
      .cfg_o    (cfg_vec[c]),
      .alarm_o  (alm_vec[c]),
      .irq_o    (irq_vec[c])
    );
    assign al_en_vec[c] = cfg_vec[c].al_en;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trim_q <= '0;
      test_q <= DW'(TEST_RST);
    end else begin
      if (trim_wr) trim_q <= wdata_i;
      if (test_wr) test_q <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (aligned) begin
      if (idx == IDX_W'(IDX_STATUS)) rdata_o = DW'(flag_vec);
      if (idx == IDX_W'(IDX_TIME))   rdata_o = time_q;
      if (idx == IDX_W'(IDX_TRIM))   rdata_o = trim_q;
      if (idx == IDX_W'(IDX_TEST))   rdata_o = test_q;
      for (int c = 0; c < NUM_ALARM; c++) begin
        if (idx == IDX_W'(IDX_CFG0 + c)) rdata_o = DW'(cfg_vec[c]);
        if (idx == IDX_W'(IDX_ALM0 + c)) rdata_o = alm_vec[c];
      end
    end
  end

  assign irq_o = |irq_vec;
endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk import rtc_pkg::*; #(
  parameter int DW     = 32,
  parameter int ADDR_W = 6
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 tick_i,
  input logic                 fast_i,
  input logic                 req_i,
  input logic                 we_i,
  input logic [ADDR_W-1:0]    addr_i,
  input logic [DW-1:0]        wdata_i,
  input logic                 irq_o,
  input logic [DW-1:0]        time_i,
  input logic [NUM_ALARM-1:0] flag_i,
  input logic [NUM_ALARM-1:0] en_i
);
  logic bus_time_wr, bus_stat_wr;
  assign bus_time_wr = req_i && we_i && (addr_i == ADDR_W'(IDX_TIME * 4));
  assign bus_stat_wr = req_i && we_i && (addr_i == ADDR_W'(IDX_STATUS * 4));

  // R2
  tick_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !bus_time_wr && !(req_i && we_i && addr_i[ADDR_W-1:2] == (ADDR_W-2)'(IDX_TIME)))
      |=> time_i == DW'($past(time_i) + 1'b1));

  // R3
  time_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_time_wr |=> time_i == $past(wdata_i));

  // R7
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|flag_i));

  // R7
  irq_gone_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i == '0) |-> !irq_o);

  for (genvar c = 0; c < NUM_ALARM; c++) begin : g_c
    // R5
    flag_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flag_i[c]) |-> $past(tick_i || fast_i));

    // R6
    w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_stat_wr && wdata_i[c] && !tick_i && !fast_i) |=> !flag_i[c]);
  end
endmodule

bind rtc_core rtc_core_chk #(.DW(DW), .ADDR_W(ADDR_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_i  (tick_i),
  .fast_i  (fast_i),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .irq_o   (irq_o),
  .time_i  (time_q),
  .flag_i  (flag_vec),
  .en_i    (al_en_vec)
);

// File: tb/sim_rtc_core.sv
`timescale 1ns/1ps
module sim_rtc_core;
  localparam logic [5:0] A_STAT = 6'h00, A_CFG0 = 6'h04, A_CFG1 = 6'h08,
                         A_TIME = 6'h0C, A_ALM0 = 6'h10, A_ALM1 = 6'h14,
                         A_TRIM = 6'h18, A_TEST = 6'h1C;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        tick = 1'b0, fast = 1'b0, req = 1'b0, we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        irq;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  rtc_core u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .fast_i(fast),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic t = 1'b0);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d; tick = t;
    @(negedge clk);
    req = 1'b0; we = 1'b0; tick = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    req = 1'b0;
  endtask

  task automatic pulse(input bit is_fast);
    @(negedge clk);
    if (is_fast) fast = 1'b1; else tick = 1'b1;
    @(negedge clk);
    fast = 1'b0; tick = 1'b0;
  endtask

  task automatic rchk(input string r, input logic [5:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(r, v, exp);
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rchk("R1 status", A_STAT, 0);
    rchk("R1 time",   A_TIME, 0);
    rchk("R1 alm0",   A_ALM0, 0);
    rchk("R1 alm1",   A_ALM1, 0);
    rchk("R1 cfg0",   A_CFG0, 0);
    rchk("R1 cfg1",   A_CFG1, 0);
    rchk("R1 trim",   A_TRIM, 0);
    rchk("R1 test",   A_TEST, 32'hFF);
    check("R1 irq", {31'b0, irq}, 0);

    // R4 register storage
    wr(A_CFG0, 32'hFFFF_FFFF);  rchk("R4 cfg0 mask", A_CFG0, 32'h7);
    wr(A_CFG1, 32'h0000_0005);  rchk("R4 cfg1", A_CFG1, 32'h5);
    wr(A_ALM0, 32'hDEAD_BEEF);  rchk("R4 alm0", A_ALM0, 32'hDEAD_BEEF);
    wr(A_ALM1, 32'h1234_5678);  rchk("R4 alm1", A_ALM1, 32'h1234_5678);
    wr(A_CFG0, 0); wr(A_CFG1, 0);

    // R2 increment and wrap; R3 load
    wr(A_TIME, 32'hFFFF_FFFE);  rchk("R3 load", A_TIME, 32'hFFFF_FFFE);
    pulse(0);                   rchk("R2 inc", A_TIME, 32'hFFFF_FFFF);
    pulse(0);                   rchk("R2 wrap", A_TIME, 32'h0);
    wr(A_TIME, 32'd100, 1'b1);  rchk("R3 write beats tick", A_TIME, 32'd100);

    // R10 trim storage, no effect on counting
    wr(A_TRIM, 32'h0000_1234);  rchk("R10 trim", A_TRIM, 32'h1234);
    pulse(0);                   rchk("R10 count unaffected", A_TIME, 32'd101);

    // R9 test word
    wr(A_TEST, 0);              rchk("R9 cleared", A_TEST, 0);
    wr(A_TEST, 32'hA5);         rchk("R9 hold", A_TEST, 32'hA5);
    wr(A_TEST, 0);

    // R11 unmapped and misaligned
    wr(6'h20, 32'hFFFF_FFFF);   rchk("R11 unmapped read", 6'h20, 0);
    wr(6'h0D, 32'hFFFF_FFFF);   rchk("R11 misaligned read", 6'h0D, 0);
    rchk("R11 time untouched", A_TIME, 32'd101);
    rchk("R11 test untouched", A_TEST, 0);

    // R5 sweep: both channels, alarm distance 0..5, six ticks
    for (int c = 0; c < 2; c++) begin
      for (int k = 0; k < 6; k++) begin
        wr(A_STAT, 32'h3);
        wr(c == 0 ? A_ALM0 : A_ALM1, 32'd40 + k);
        wr(A_TIME, 32'd40);
        for (int j = 1; j <= 6; j++) begin
          pulse(0);
          rd(A_STAT, v);
          check($sformatf("R5 ch%0d k%0d j%0d", c, k, j), {31'b0, v[c]},
                (k >= 1 && j >= k) ? 32'd1 : 32'd0);
        end
        check("R5 no irq when disabled", {31'b0, irq}, 0);
      end
    end

    // R7 / R6 interrupt gating and write-one-to-clear
    wr(A_ALM1, 32'hFFFF);
    wr(A_STAT, 32'h3);
    wr(A_ALM0, 32'd200);
    wr(A_TIME, 32'd199);
    wr(A_CFG0, 32'h1);
    pulse(0);
    #1 check("R7 irq on", {31'b0, irq}, 1);
    wr(A_CFG0, 0);
    #1 check("R7 irq off by enable", {31'b0, irq}, 0);
    wr(A_CFG0, 32'h1);
    #1 check("R7 irq back", {31'b0, irq}, 1);
    wr(A_STAT, 32'h2);
    rchk("R6 write zero keeps flag", A_STAT, 32'h1);
    wr(A_STAT, 32'h1);
    rchk("R6 clear", A_STAT, 0);
    #1 check("R7 irq off by clear", {31'b0, irq}, 0);
    wr(A_CFG0, 0);

    // R6 set wins over same-cycle clear
    wr(A_TIME, 32'd199);
    wr(A_STAT, 32'h1, 1'b1);
    rchk("R6 set wins", A_STAT, 32'h1);
    wr(A_STAT, 32'h3);

    // R8 periodic modes on channel 1
    wr(A_TIME, 32'd10);
    wr(A_CFG1, 32'h6);
    pulse(0);                   rchk("R8 1Hz tick sets", A_STAT, 32'h2);
    wr(A_STAT, 32'h3);
    pulse(1);                   rchk("R8 1Hz ignores fast", A_STAT, 0);
    wr(A_CFG1, 32'h2);
    pulse(0);                   rchk("R8 fast mode ignores tick", A_STAT, 0);
    pulse(1);                   rchk("R8 fast sets", A_STAT, 32'h2);
    wr(A_STAT, 32'h3);
    wr(A_CFG1, 32'h0);
    pulse(1);                   rchk("R8 fast no effect when off", A_STAT, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule